// File: doc/BRIEF.md
# Telephone Keypad Scanner with Debounce

This block reads a 4 by 4 telephone keypad through active-low row and column lines. It reports each accepted press as a 4-bit key code together with a strobe that lasts one clock. Two kinds of keypad are supported. On a two-contact matrix keypad, a press grounds one row and one column. On a single-contact keypad, a press joins one row to one column. The block tells the two kinds apart by which lines it drives low. While the block waits, it drives the columns low and leaves the rows to their pull-ups. A press of either kind then pulls one row low.

After that first activity, the block starts its timebase, which divides the clock by `DIV_CLKS`. On each tick it swaps sides. In one phase it drives the columns low and reads the rows. In the other phase it drives the rows low and reads the columns. A key is accepted only after `DEB_TICKS` consecutive samples each show exactly one active line, and that line matches the earlier sample on the same side. A hook-state input forces the block inactive while the handset is on-hook. In that state nothing is driven and key activity has no effect.

Top module: `keypad_scan`

## Requirements
- R1: While `on_hook_i` is 1, `drive_rows_o` and `drive_cols_o` are both 0 in the same cycle. From the next cycle on, `scan_busy_o` and `key_valid_o` stay 0, whatever the keypad lines do.
- R2: Off-hook with no line low, the block sits idle: `drive_cols_o`=1, `drive_rows_o`=0, `scan_busy_o`=0. It leaves idle only when some row reads low.
- R3: While `scan_busy_o` is 1, exactly one of `drive_rows_o` and `drive_cols_o` is 1. The active side swaps on every timebase tick, one tick every `DIV_CLKS` clocks, starting with the columns driven.
- R4: A two-contact keypad press (row and column both low, whatever is driven) is accepted and reported.
- R5: A single-contact keypad press (the row reads low only while the columns are driven, the column reads low only while the rows are driven) is accepted and reported.
- R6: A strobe comes no earlier than `DEB_TICKS` ticks after scanning starts. A press held for half that time produces no strobe.
- R7: A sample with more than one low row, or more than one low column, is invalid and restarts the debounce count. While it persists, no strobe occurs. Once a single key remains, that key is accepted.
- R8: Each press gives exactly one `key_valid_o` pulse, one cycle wide. Holding the key gives no repeat. After release, `scan_busy_o` returns to 0 within a few ticks, and only then can a new key be accepted.
- R9: `key_code_o` is set by the row r and column c, both counted from 0 at bit 0. Rows 0 to 2 in columns 0 to 2 give 3r+c+1, which is 1 to 9. Row 3 gives 11 in column 0, 10 in column 1 and 12 in column 2. Column 3 gives 13, 14 and 15 for rows 0 to 2, and 0 for row 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| on_hook_i | input | 1 | 1 while the handset is on-hook |
| row_n_i | input | ROWS | Row line levels, low = active |
| col_n_i | input | COLS | Column line levels, low = active |
| drive_rows_o | output | 1 | 1: rows driven low, columns sensed |
| drive_cols_o | output | 1 | 1: columns driven low, rows sensed |
| scan_busy_o | output | 1 | Timebase running, verification scan in progress |
| key_valid_o | output | 1 | One-cycle strobe for an accepted key |
| key_code_o | output | 4 | Code of the last accepted key |

## Verification
The bench builds the block with `DIV_CLKS`=4 and `DEB_TICKS`=6, so that a full debounce takes only a few dozen clocks. This makes it practical to run many presses, short presses, held keys and chords. A keypad model inside the bench answers the block's drive outputs in the way each keypad kind would. The checks cover codes in every column and in the bottom row for both keypad kinds, and the latency window from press to strobe in clocks.

// File: rtl/kps_pkg.sv
package kps_pkg;

   typedef enum logic {
      KPS_IDLE = 1'b0,
      KPS_SCAN = 1'b1
   } kps_state_e;

   // Map a row/column position to the reported key code (bottom-right wraps to 0).
   function automatic logic [3:0] kps_key_code(input logic [1:0] r, input logic [1:0] c);
      logic [3:0] code;
      if (c == 2'd3)
         code = 4'd13 + {2'b00, r};
      else if (r == 2'd3)
         code = (c == 2'd0) ? 4'd11 : (c == 2'd1) ? 4'd10 : 4'd12;
      else
         code = 4'({r, 1'b0} + {2'b00, r}) + {2'b00, c} + 4'd1;
      return code;
   endfunction

endpackage

// File: rtl/kps_timebase.sv
module kps_timebase #(
   parameter int DIV_CLKS = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   output logic tick
);
   generate
      if (DIV_CLKS == 1) begin : g_direct
         assign tick = en;
      end else begin : g_divide
         localparam int PW = $clog2(DIV_CLKS);
         logic [PW-1:0] pre_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               pre_q <= '0;
            else if (!en || pre_q == PW'(DIV_CLKS - 1))
               pre_q <= '0;
            else
               pre_q <= pre_q + 1'b1;
         end
         assign tick = en && (pre_q == PW'(DIV_CLKS - 1));
      end
   endgenerate
endmodule

// File: rtl/kps_line_decode.sv
module kps_line_decode #(
   parameter int N = 4,
   localparam int IW = (N > 1) ? $clog2(N) : 1,
   localparam int NW = $clog2(N + 1)
) (
   input  logic [N-1:0]  lines_n,
   output logic          any,
   output logic          one,
   output logic [IW-1:0] idx
);
   logic [N-1:0] low;
   logic [NW-1:0] cnt;

   generate
      for (genvar i = 0; i < N; i++) begin : g_inv
         assign low[i] = ~lines_n[i];
      end
   endgenerate

   always_comb begin
      cnt = '0;
      idx = '0;
      for (int i = 0; i < N; i++) begin
         if (low[i]) begin
            cnt = cnt + 1'b1;
            idx = IW'(i);
         end
      end
   end

   assign any = |low;
   assign one = (cnt == NW'(1));
endmodule

// File: rtl/kps_ctrl.sv
module kps_ctrl
   import kps_pkg::*;
#(
   parameter int ROWS      = 4,
   parameter int COLS      = 4,
   parameter int DEB_TICKS = 24,
   localparam int RW = $clog2(ROWS),
   localparam int CW = $clog2(COLS),
   localparam int NW = $clog2(DEB_TICKS + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          on_hook,
   input  logic          tick,
   input  logic          row_any,
   input  logic          row_one,
   input  logic [RW-1:0] row_idx,
   input  logic          col_any,
   input  logic          col_one,
   input  logic [CW-1:0] col_idx,
   output logic          scan_en,
   output logic          drive_rows,
   output logic          drive_cols,
   output logic          key_valid,
   output logic [3:0]    key_code
);
   kps_state_e    state_q;
   logic          phase_q;   // 0: columns driven, rows sensed; 1: rows driven
   logic [NW-1:0] cnt_q;
   logic [RW-1:0] row_q;
   logic [CW-1:0] col_q;
   logic          done_q;

   logic       smp_any, smp_ok;
   logic [3:0] code_now;

   always_comb begin
      if (!phase_q) begin
         smp_any  = row_any;
         smp_ok   = row_one && (row_idx == row_q);
         code_now = kps_key_code(2'(row_idx), 2'(col_q));
      end else begin
         smp_any  = col_any;
         smp_ok   = col_one && (col_idx == col_q);
         code_now = kps_key_code(2'(row_q), 2'(col_idx));
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= KPS_IDLE;
         phase_q   <= 1'b0;
         cnt_q     <= '0;
         row_q     <= '0;
         col_q     <= '0;
         done_q    <= 1'b0;
         key_valid <= 1'b0;
         key_code  <= '0;
      end else begin
         key_valid <= 1'b0;
         if (on_hook) begin
            state_q <= KPS_IDLE;
         end else begin
            case (state_q)
               KPS_IDLE: begin
                  if (row_any) begin
                     state_q <= KPS_SCAN;
                     phase_q <= 1'b0;
                     cnt_q   <= '0;
                     done_q  <= 1'b0;
                  end
               end
               KPS_SCAN: begin
                  if (tick) begin
                     phase_q <= ~phase_q;
                     if (!smp_any) begin
                        state_q <= KPS_IDLE;
                     end else begin
                        if (!phase_q) row_q <= row_idx;
                        else          col_q <= col_idx;
                        if (!smp_ok) begin
                           cnt_q <= '0;
                        end else if (!done_q) begin
                           if (cnt_q == NW'(DEB_TICKS - 1)) begin
                              key_valid <= 1'b1;
                              key_code  <= code_now;
                              done_q    <= 1'b1;
                           end else begin
                              cnt_q <= cnt_q + 1'b1;
                           end
                        end
                     end
                  end
               end
               default: state_q <= KPS_IDLE;
            endcase
         end
      end
   end

   assign scan_en    = (state_q == KPS_SCAN);
   assign drive_cols = !on_hook && ((state_q == KPS_IDLE) || !phase_q);
   assign drive_rows = !on_hook && (state_q == KPS_SCAN) && phase_q;
endmodule

// File: rtl/keypad_scan.sv
module keypad_scan #(
   parameter int ROWS      = 4,
   parameter int COLS      = 4,
   parameter int DIV_CLKS  = 1000,
   parameter int DEB_TICKS = 24,
   localparam int RW = $clog2(ROWS),
   localparam int CW = $clog2(COLS)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            on_hook_i,
   input  logic [ROWS-1:0] row_n_i,
   input  logic [COLS-1:0] col_n_i,
   output logic            drive_rows_o,
   output logic            drive_cols_o,
   output logic            scan_busy_o,
   output logic            key_valid_o,
   output logic [3:0]      key_code_o
);
   generate
      if (ROWS != 4 || COLS != 4) begin : g_bad_size
         $error("keypad_scan: code map needs a 4x4 keypad");
      end
      if (DIV_CLKS < 1) begin : g_bad_div
         $error("keypad_scan: DIV_CLKS must be at least 1");
      end
      if (DEB_TICKS < 2) begin : g_bad_deb
         $error("keypad_scan: DEB_TICKS must be at least 2");
      end
   endgenerate

   logic          tick;
   logic          row_any, row_one, col_any, col_one;
   logic [RW-1:0] row_idx;
   logic [CW-1:0] col_idx;

   kps_timebase #(.DIV_CLKS(DIV_CLKS)) i_tb (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (scan_busy_o),
      .tick  (tick)
   );

   kps_line_decode #(.N(ROWS)) i_rows (
      .lines_n (row_n_i),
      .any     (row_any),
      .one     (row_one),
      .idx     (row_idx)
   );

   kps_line_decode #(.N(COLS)) i_cols (
      .lines_n (col_n_i),
      .any     (col_any),
      .one     (col_one),
      .idx     (col_idx)
   );

   kps_ctrl #(.ROWS(ROWS), .COLS(COLS), .DEB_TICKS(DEB_TICKS)) i_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .on_hook    (on_hook_i),
      .tick       (tick),
      .row_any    (row_any),
      .row_one    (row_one),
      .row_idx    (row_idx),
      .col_any    (col_any),
      .col_one    (col_one),
      .col_idx    (col_idx),
      .scan_en    (scan_busy_o),
      .drive_rows (drive_rows_o),
      .drive_cols (drive_cols_o),
      .key_valid  (key_valid_o),
      .key_code   (key_code_o)
   );
endmodule

// File: rtl/kps_chk.sv
module kps_chk #(
   parameter int DEB_TICKS = 24,
   localparam int TW = $clog2(DEB_TICKS + 1)
) (
   input logic clk,
   input logic rst_n,
   input logic on_hook_i,
   input logic tick,
   input logic drive_rows_o,
   input logic drive_cols_o,
   input logic scan_busy_o,
   input logic key_valid_o
);
   logic [TW-1:0] ticks_q;
   logic          fired_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ticks_q <= '0;
         fired_q <= 1'b0;
      end else begin
         if (!scan_busy_o)
            ticks_q <= '0;
         else if (tick && ticks_q != TW'(DEB_TICKS))
            ticks_q <= ticks_q + 1'b1;
         if (!scan_busy_o)
            fired_q <= 1'b0;
         else if (key_valid_o)
            fired_q <= 1'b1;
      end
   end

   // R1
   on_hook_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      on_hook_i |=> !scan_busy_o && !key_valid_o);

   // R1
   on_hook_undriven_chk: assert property (@(posedge clk) disable iff (!rst_n)
      on_hook_i |-> !drive_rows_o && !drive_cols_o);

   // R2
   idle_static_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!on_hook_i && !scan_busy_o) |-> (drive_cols_o && !drive_rows_o));

   // R3
   one_side_chk: assert property (@(posedge clk) disable iff (!rst_n)
      scan_busy_o && !on_hook_i |-> $onehot({drive_rows_o, drive_cols_o}));

   // R3
   swap_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (scan_busy_o && !on_hook_i && tick) |=> (!scan_busy_o || on_hook_i || !$stable(drive_rows_o)));

   // R6
   debounce_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
      key_valid_o |-> (ticks_q >= TW'(DEB_TICKS)));

   // R8
   single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      key_valid_o |=> !key_valid_o);

   // R8
   once_per_press_chk: assert property (@(posedge clk) disable iff (!rst_n)
      key_valid_o |-> !fired_q);
endmodule

bind keypad_scan kps_chk #(.DEB_TICKS(DEB_TICKS)) i_kps_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .on_hook_i    (on_hook_i),
   .tick         (tick),
   .drive_rows_o (drive_rows_o),
   .drive_cols_o (drive_cols_o),
   .scan_busy_o  (scan_busy_o),
   .key_valid_o  (key_valid_o)
);

// File: tb/test_keypad_scan.sv
module test_keypad_scan;
   localparam int CLK_PERIOD = 10;
   localparam int DIV        = 4;
   localparam int DEB        = 6;
   localparam int LAT_MIN    = DEB * DIV;
   localparam int LAT_MAX    = (DEB + 4) * DIV + 2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       on_hook = 1'b1;
   logic [3:0] row_n, col_n;
   logic       drive_rows, drive_cols, scan_busy, key_valid;
   logic [3:0] key_code;

   logic [15:0] mask = '0;     // pressed keys, bit r*4+c
   logic        two_contact = 1'b1;

   int checks = 0;
   int errors = 0;
   int strobes = 0;
   logic [3:0] last_code = '0;
   bit done = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   keypad_scan #(.DIV_CLKS(DIV), .DEB_TICKS(DEB)) i_keypad_scan (
      .clk          (clk),
      .rst_n        (rst_n),
      .on_hook_i    (on_hook),
      .row_n_i      (row_n),
      .col_n_i      (col_n),
      .drive_rows_o (drive_rows),
      .drive_cols_o (drive_cols),
      .scan_busy_o  (scan_busy),
      .key_valid_o  (key_valid),
      .key_code_o   (key_code)
   );

   // Keypad model answering the block's drive outputs
   always_comb begin
      row_n = '1;
      col_n = '1;
      for (int r = 0; r < 4; r++) begin
         for (int c = 0; c < 4; c++) begin
            if (mask[r*4+c]) begin
               if (two_contact) begin
                  row_n[r] = 1'b0;
                  col_n[c] = 1'b0;
               end else begin
                  if (drive_cols) row_n[r] = 1'b0;
                  if (drive_rows) col_n[c] = 1'b0;
               end
            end
         end
      end
   end

   always @(posedge clk) begin
      if (key_valid) begin
         strobes   <= strobes + 1;
         last_code <= key_code;
      end
   end

   function automatic int exp_code(input int r, input int c);
      int t[4][4] = '{'{1, 2, 3, 13}, '{4, 5, 6, 14}, '{7, 8, 9, 15}, '{11, 10, 12, 0}};
      return t[r][c];
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wait_clks(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic wait_idle(input string req);
      int n = 0;
      while (scan_busy && n < 20 * DIV) begin
         @(negedge clk);
         n++;
      end
      check(!scan_busy, req, int'(scan_busy), 0);
   endtask

   // R4 R5 R6 R8 R9: one full press, code, latency, single strobe, release
   task automatic press_key(input int r, input int c, input bit two, input string req);
      int base, lat;
      two_contact = two;
      base = strobes;
      mask = '0;
      mask[r*4+c] = 1'b1;
      lat = 0;
      for (int i = 0; i < 200; i++) begin
         @(negedge clk);
         lat = i + 1;
         if (strobes != base) break;
      end
      check(strobes == base + 1, req, strobes - base, 1);
      check(int'(last_code) == exp_code(r, c), {req, "/R9 code"}, int'(last_code), exp_code(r, c));
      check(lat >= LAT_MIN && lat <= LAT_MAX, {req, "/R6 latency"}, lat, LAT_MIN);
      wait_clks(20 * DIV);
      check(strobes == base + 1, "R8 held key no repeat", strobes - base, 1);
      mask = '0;
      wait_idle("R8 release ends scan");
   endtask

   task automatic test_reset;
      check(!key_valid && !scan_busy, "R1 reset quiet", int'(scan_busy), 0);
      check(!drive_rows && !drive_cols, "R1 reset undriven", int'({drive_rows, drive_cols}), 0);
   endtask

   task automatic test_on_hook;
      int base = strobes;
      on_hook = 1'b1;
      two_contact = 1'b1;
      mask = 16'h0020;
      wait_clks(30 * DIV);
      check(strobes == base, "R1 on-hook press ignored", strobes - base, 0);
      check(!scan_busy, "R1 on-hook no scan", int'(scan_busy), 0);
      check(!drive_rows && !drive_cols, "R1 on-hook undriven", int'({drive_rows, drive_cols}), 0);
      mask = '0;
      wait_clks(2);
   endtask

   task automatic test_idle;
      bit ok = 1'b1;
      on_hook = 1'b0;
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         if (scan_busy || !drive_cols || drive_rows) ok = 1'b0;
      end
      check(ok, "R2 idle static", int'({scan_busy, drive_cols, drive_rows}), 3'b010);
   endtask

   task automatic test_alternation;
      int swaps = 0;
      bit both = 1'b0;
      logic prev;
      two_contact = 1'b0;
      mask = 16'h0100;
      @(negedge clk);
      check(scan_busy && drive_cols && !drive_rows, "R3 scan starts on columns",
            int'({scan_busy, drive_cols, drive_rows}), 3'b110);
      prev = drive_rows;
      for (int i = 0; i < 20 * DIV; i++) begin
         @(negedge clk);
         if (drive_rows && drive_cols) both = 1'b1;
         if (drive_rows != prev) swaps++;
         prev = drive_rows;
      end
      check(!both && swaps >= 19 && swaps <= 21, "R3 alternation per tick", swaps, 20);
      mask = '0;
      wait_idle("R3 release");
   endtask

   task automatic test_short_press;
      int base = strobes;
      two_contact = 1'b1;
      mask = 16'h0004;
      wait_clks((DEB / 2) * DIV);
      mask = '0;
      wait_clks(20 * DIV);
      check(strobes == base, "R6 short press rejected", strobes - base, 0);
   endtask

   task automatic test_chord;
      int base = strobes;
      int lat = 0;
      two_contact = 1'b1;
      mask = '0;
      mask[1*4+1] = 1'b1;
      mask[2*4+1] = 1'b1;
      wait_clks(30 * DIV);
      check(strobes == base, "R7 two rows invalid", strobes - base, 0);
      check(scan_busy, "R7 keeps scanning", int'(scan_busy), 1);
      mask[2*4+1] = 1'b0;
      for (int i = 0; i < 200; i++) begin
         @(negedge clk);
         lat = i + 1;
         if (strobes != base) break;
      end
      check(strobes == base + 1 && int'(last_code) == exp_code(1, 1), "R7 remaining key accepted",
            int'(last_code), exp_code(1, 1));
      check(lat >= LAT_MIN && lat <= LAT_MAX, "R7 debounce restarted", lat, LAT_MIN);
      mask = '0;
      wait_idle("R7 release");
   endtask

   initial begin
      wait_clks(3);
      test_reset();
      rst_n = 1'b1;
      wait_clks(2);
      test_on_hook();
      test_idle();
      press_key(0, 0, 1'b1, "R4 two-contact 1");
      press_key(1, 2, 1'b1, "R4 two-contact 6");
      press_key(3, 1, 1'b1, "R4 two-contact 0");
      press_key(3, 3, 1'b1, "R4 two-contact last");
      press_key(3, 0, 1'b0, "R5 single-contact star");
      press_key(2, 2, 1'b0, "R5 single-contact 9");
      press_key(3, 2, 1'b0, "R5 single-contact hash");
      press_key(0, 3, 1'b0, "R5 single-contact col3");
      test_alternation();
      test_short_press();
      test_chord();
      test_on_hook();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(200000 * CLK_PERIOD);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule